// File: doc/BRIEF.md
# Power-Up Protocol Selector with Answer-to-Reset

This block sits behind the card clock and the reset pin of a secure-memory device. After the power-on reset is released, it watches the reset pin to decide which protocol the rest of the device will speak. If the pin stays high (it has an internal pull-up), the block picks the synchronous two-wire mode. It then raises a ready flag for the command decoder once the host has supplied a short run of warm-up clock pulses. If the host holds the pin low for a long enough run of card clocks and then raises it, the block picks the asynchronous smart-card mode. In that mode it sends the programmed 64-bit answer-to-reset word on the single I/O line, one bit per elementary time unit of 372 card clocks.

The choice is locked until power is removed. A later reset pulse in asynchronous mode stops any answer-to-reset in progress and arms the same long-low detection again. A long pulse restarts the answer-to-reset from its first bit. A short pulse leaves the line idle. In synchronous mode, reset pulses have no effect. The I/O output is a drive-low enable for an open-drain pad: 1 pulls the line low, and 0 releases it high.

Top module: `proto_select_atr`

## Requirements
- R1: While the power-on reset is asserted and after it is released, and before any decision, mode_o is 2'b00, io_drive_low_o is 0 and sync_ready_o is 0.
- R2: If the reset pin is sampled high at a rising clock edge after fewer than ARM_CYCLES (400) consecutive low samples since power-on reset, mode_o becomes 2'b01 (synchronous) from that edge on. This includes the case where the pin is high at the very first edge.
- R3: If the reset pin is sampled high after at least ARM_CYCLES consecutive low samples, mode_o becomes 2'b10 (asynchronous) at that edge, and the start bit of the first character is driven from that same edge.
- R4: In synchronous mode, sync_ready_o is 0 after the first SYNC_PULSES-1 (4) edges that follow the decision edge. It rises after the SYNC_PULSES-th (5th) such edge and then stays 1.
- R5: The answer-to-reset is ATR_BYTES (8) characters, starting with byte atr_word_i[7:0] and going upward. Each character is built as follows:
  - one low start bit;
  - 8 data bits, LSB first;
  - one even-parity bit, so that the data plus parity hold an even number of ones;
  - GUARD_ETU (2) released guard bits.
- R6: Every bit of the answer-to-reset lasts exactly ETU_CLKS (372) clock edges.
- R7: Once mode_o is 2'b01 or 2'b10, it never changes, whatever the reset pin does. In synchronous mode, io_drive_low_o stays 0 and sync_ready_o stays 1 through reset-pin pulses.
- R8: In asynchronous mode, a low sample of the reset pin aborts the answer-to-reset: io_drive_low_o is 0 from that edge on.
- R9: After an abort, the pin returning high after at least ARM_CYCLES low samples restarts the answer-to-reset from the first start bit. Returning high after fewer low samples leaves the line released.
- R10: After the last guard bit of the last character, the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| rst_pin_i | input | 1 | Reset pin level (idles high through the pull-up) |
| atr_word_i | input | ATR_BYTES*8 | Programmed answer-to-reset word, byte 0 in the low bits |
| mode_o | output | 2 | 00 undecided, 01 synchronous, 10 asynchronous |
| io_drive_low_o | output | 1 | 1 pulls the I/O line low |
| sync_ready_o | output | 1 | Synchronous command decoder may accept commands |

## Verification
The mode decision shows on mode_o right after the edge that samples the pin high, and the first start bit appears after that same edge. The bench therefore samples two time units after that edge. It checks each answer-to-reset bit twice: once just after the edge that opens it and once just after the last edge before the next bit, i.e. 0 and 371 edges into the unit. This pins both ends of the 372-clock window. The ready flag is checked after the fourth and fifth edges past the decision. The abort is checked right after the edge that samples the pin low. Threshold runs of 399 and 400 low samples bracket the arming count.

// File: rtl/proto_sel_pkg.sv
package proto_sel_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_ASYNC = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_SYNC,
    ST_ASYNC,
    ST_ARM
  } sel_state_e;
endpackage

// File: rtl/etu_tick.sv
module etu_tick #(
  parameter int ETU_CLKS = 372
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = $clog2(ETU_CLKS);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(ETU_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter #(
  parameter int ATR_BYTES = 8,
  parameter int ETU_CLKS  = 372,
  parameter int GUARD_ETU = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   abort_i,
  input  logic [ATR_BYTES*8-1:0] atr_i,
  output logic                   drive_low_o
);
  localparam int CHAR_BITS = 10 + GUARD_ETU;
  localparam int BW        = $clog2(CHAR_BITS);
  localparam int YW        = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;

  logic          active_q;
  logic [BW-1:0] bit_q;
  logic [YW-1:0] byte_q;
  logic          tick;
  logic [7:0]    chars [ATR_BYTES];
  logic [7:0]    cur;
  logic          lvl;

  for (genvar g = 0; g < ATR_BYTES; g++) begin : g_chars
    assign chars[g] = atr_i[g*8 +: 8];
  end

  etu_tick #(.ETU_CLKS(ETU_CLKS)) etu_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .clear_i(start_i | abort_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      byte_q   <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      byte_q   <= '0;
    end else if (active_q && tick) begin
      if (bit_q == BW'(CHAR_BITS - 1)) begin
        bit_q <= '0;
        if (byte_q == YW'(ATR_BYTES - 1)) active_q <= 1'b0;
        else                              byte_q   <= byte_q + YW'(1);
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  // frame: start, 8 data LSB first, even parity, guard
  always_comb begin
    cur = chars[byte_q];
    if (bit_q == '0)            lvl = 1'b0;
    else if (bit_q <= BW'(8))   lvl = cur[3'(bit_q - BW'(1))];
    else if (bit_q == BW'(9))   lvl = ^cur;
    else                        lvl = 1'b1;
  end

  assign drive_low_o = active_q & ~lvl;
endmodule

// File: rtl/proto_mode_fsm.sv
module proto_mode_fsm
  import proto_sel_pkg::*;
#(
  parameter int ARM_CYCLES  = 400,
  parameter int SYNC_PULSES = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  output logic       start_o,
  output logic       abort_o,
  output logic [1:0] mode_o,
  output logic       ready_o
);
  localparam int LW = $clog2(ARM_CYCLES + 1);
  localparam int PW = $clog2(SYNC_PULSES + 1);

  sel_state_e    state_q, state_d;
  logic [LW-1:0] low_q, low_d;
  logic [PW-1:0] pulse_q;
  logic          armed;

  assign armed = (low_q == LW'(ARM_CYCLES));

  always_comb begin
    state_d = state_q;
    low_d   = low_q;
    start_o = 1'b0;
    abort_o = 1'b0;
    unique case (state_q)
      ST_WAIT, ST_ARM: begin
        if (!pin_i) begin
          abort_o = (state_q == ST_ARM);
          if (!armed) low_d = low_q + LW'(1);
        end else begin
          low_d = '0;
          if (armed) begin
            start_o = 1'b1;
            state_d = ST_ASYNC;
          end else begin
            state_d = (state_q == ST_WAIT) ? ST_SYNC : ST_ASYNC;
          end
        end
      end
      ST_ASYNC: begin
        if (!pin_i) begin
          abort_o = 1'b1;
          low_d   = LW'(1);
          state_d = ST_ARM;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      low_q   <= '0;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
      if (state_q == ST_SYNC && pulse_q != PW'(SYNC_PULSES))
        pulse_q <= pulse_q + PW'(1);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SYNC:         mode_o = MODE_SYNC;
      ST_ASYNC, ST_ARM: mode_o = MODE_ASYNC;
      default:         mode_o = MODE_NONE;
    endcase
  end

  assign ready_o = (state_q == ST_SYNC) && (pulse_q == PW'(SYNC_PULSES));
endmodule

// File: rtl/proto_select_atr.sv
module proto_select_atr #(
  parameter int ARM_CYCLES  = 400,
  parameter int SYNC_PULSES = 5,
  parameter int ETU_CLKS    = 372,
  parameter int ATR_BYTES   = 8,
  parameter int GUARD_ETU   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rst_pin_i,
  input  logic [ATR_BYTES*8-1:0] atr_word_i,
  output logic [1:0]             mode_o,
  output logic                   io_drive_low_o,
  output logic                   sync_ready_o
);
  logic start, abort;

  proto_mode_fsm #(
    .ARM_CYCLES (ARM_CYCLES),
    .SYNC_PULSES(SYNC_PULSES)
  ) fsm_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (rst_pin_i),
    .start_o(start),
    .abort_o(abort),
    .mode_o (mode_o),
    .ready_o(sync_ready_o)
  );

  atr_shifter #(
    .ATR_BYTES(ATR_BYTES),
    .ETU_CLKS (ETU_CLKS),
    .GUARD_ETU(GUARD_ETU)
  ) tx_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort),
    .atr_i      (atr_word_i),
    .drive_low_o(io_drive_low_o)
  );
endmodule

// File: rtl/proto_select_atr_chk.sv
module proto_select_atr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_pin_i,
  input logic [1:0] mode_o,
  input logic       io_drive_low_o,
  input logic       sync_ready_o
);
  assert_undecided_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |-> (!io_drive_low_o && !sync_ready_o));

  assert_ready_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ready_o |=> sync_ready_o);

  assert_ready_only_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ready_o |-> (mode_o == 2'b01));

  assert_mode_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'b00) |=> (mode_o == $past(mode_o)));

  assert_no_drive_in_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |-> !io_drive_low_o);

  assert_abort_releases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'b10) && !rst_pin_i) |=> !io_drive_low_o);
endmodule

bind proto_select_atr proto_select_atr_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rst_pin_i     (rst_pin_i),
  .mode_o        (mode_o),
  .io_drive_low_o(io_drive_low_o),
  .sync_ready_o  (sync_ready_o)
);

// File: tb/proto_select_atr_tb.sv
module proto_select_atr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ARM        = 400;
  localparam int PULSES     = 5;
  localparam int ETU        = 372;
  localparam int NBYTES     = 8;
  localparam int GUARD      = 2;
  localparam int CHAR_BITS  = 10 + GUARD;
  localparam int TOTAL_BITS = NBYTES * CHAR_BITS;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                pin = 1'b1;
  logic [NBYTES*8-1:0] atr = '0;
  logic [1:0]          mode;
  logic                drv;
  logic                rdy;

  int checks = 0;
  int errors = 0;
  int unsigned seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  proto_select_atr dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rst_pin_i     (pin),
    .atr_word_i    (atr),
    .mode_o        (mode),
    .io_drive_low_o(drv),
    .sync_ready_o  (rdy)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // expected line-low for bit k of the whole answer
  function automatic logic exp_low(input logic [NBYTES*8-1:0] w, input int k);
    int c = k / CHAR_BITS;
    int b = k % CHAR_BITS;
    logic [7:0] by = w[c*8 +: 8];
    if (b == 0) return 1'b1;
    if (b <= 8) return ~by[b-1];
    if (b == 9) return ~(^by);
    return 1'b0;
  endfunction

  task automatic por(input logic lvl);
    rst_n = 1'b0;
    pin   = lvl;
    tick();
    check({62'd0, mode}, 64'd0, "R1 mode in reset");
    check({63'd0, drv},  64'd0, "R1 io in reset");
    tick();
    rst_n = 1'b1;
    #1;
    check({62'd0, mode}, 64'd0, "R1 mode after reset");
    check({63'd0, rdy},  64'd0, "R1 ready after reset");
  endtask

  // pin is low; hold it for n more sampled edges, then raise and cross one edge
  task automatic low_then_high(input int n);
    pin = 1'b0;
    repeat (n) tick();
    pin = 1'b1;
    tick();
  endtask

  // called just after the edge that started the answer
  task automatic check_atr(input string tag);
    for (int k = 0; k < TOTAL_BITS; k++) begin
      check({63'd0, drv}, {63'd0, exp_low(atr, k)}, {tag, " R5 R6 bit start"});
      repeat (ETU - 1) tick();
      check({63'd0, drv}, {63'd0, exp_low(atr, k)}, {tag, " R6 bit end"});
      tick();
    end
    check({63'd0, drv}, 64'd0, {tag, " R10 released after last"});
    repeat (50) tick();
    check({63'd0, drv}, 64'd0, {tag, " R10 stays released"});
    check({62'd0, mode}, 64'd2, {tag, " R3 mode async"});
  endtask

  task automatic sync_ready_seq(input string tag);
    check({62'd0, mode}, 64'd1, {tag, " R2 mode sync"});
    check({63'd0, rdy},  64'd0, {tag, " R4 not ready at entry"});
    repeat (PULSES - 1) tick();
    check({63'd0, rdy},  64'd0, {tag, " R4 not ready after 4"});
    tick();
    check({63'd0, rdy},  64'd1, {tag, " R4 ready after 5"});
    check({63'd0, drv},  64'd0, {tag, " R4 no io drive"});
  endtask

  initial begin
    seed_dummy = $urandom(32'd1234);

    // pin high from power-up: synchronous by default
    por(1'b1);
    tick();
    sync_ready_seq("default");
    pin = 1'b0;
    repeat (ARM + 20) tick();
    pin = 1'b1;
    repeat (10) tick();
    check({62'd0, mode}, 64'd1, "R7 sync locked after long pulse");
    check({63'd0, rdy},  64'd1, "R7 ready kept");
    check({63'd0, drv},  64'd0, "R7 no io in sync");

    // threshold one short: synchronous
    por(1'b0);
    low_then_high(ARM - 1);
    sync_ready_seq("edge399");

    // random short low runs
    for (int i = 0; i < 3; i++) begin
      por(1'b0);
      low_then_high(int'($urandom_range(0, ARM - 2)));
      sync_ready_seq("rand_short");
    end

    // exact threshold: asynchronous, answer starts at once
    por(1'b0);
    atr = {$urandom, $urandom};
    low_then_high(ARM);
    check({62'd0, mode}, 64'd2, "R3 mode async at 400");
    check({63'd0, rdy},  64'd0, "R3 no ready in async");
    check_atr("atr0");

    // directed pattern, then abort mid-answer
    por(1'b0);
    atr = 64'h00FF_A5_5A_01_80_7E_C3;
    low_then_high(ARM + int'($urandom_range(0, 40)));
    check({63'd0, drv}, 64'd1, "R3 start bit");
    repeat (ETU * 5 + 17) tick();
    pin = 1'b0;
    tick();
    check({63'd0, drv},  64'd0, "R8 aborted");
    check({62'd0, mode}, 64'd2, "R7 mode kept on abort");
    repeat (100) tick();
    pin = 1'b1;
    tick();
    repeat (ETU * 2) begin
      if (drv !== 1'b0) break;
      tick();
    end
    check({63'd0, drv},  64'd0, "R9 short pulse no answer");
    check({62'd0, mode}, 64'd2, "R7 mode kept after short pulse");

    // long pulse restarts from the first bit
    atr = {$urandom, $urandom};
    low_then_high(ARM);
    check({62'd0, mode}, 64'd2, "R9 mode async on restart");
    check_atr("R9 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule